// File: doc/BRIEF.md
# Bit-Granular Queue with Operation Ports

This block is a first-in first-out store of single bits. Producers hand it a 37-bit data word together with an operation word. The operation word says how many of the word's low bits to append, and whether they enter least-significant first or most-significant first. Consumers present an operation word that either takes a number of the oldest bits into a right-aligned output word, or drops a number of the oldest bits. In the take case the operation word also chooses the bit order of the result. Bits from successive appends join up across word boundaries, so a single take can gather bits that arrived in several writes.

Each of the four channels uses a valid/ready handshake. The data and its operation are consumed together, and only when both are valid and the stored bit count plus the requested count fits the capacity. An output operation waits until enough bits are stored. A take also waits until the consumer is ready for the output word.

Top module: `bit_fifo`

## Requirements
- R1: After reset the queue is empty: `out_valid_o` is low, and a take of one bit is not accepted (`outop_ready_o` low).
- R2: A data word and its input operation are consumed in the same cycle. `in_ready_o` is high only while `inop_valid_i` is high, and `inop_ready_o` is high only while `in_valid_i` is high.
- R3: The input operation's bits 13..8 give the append count n, and its bit 0 gives the order. With 1, data bits 0..n-1 enter oldest-first in rising order. With 0, they enter in falling order, starting at bit n-1.
- R4: An output operation whose bits 13..8 are nonzero is a take of n bits. With bit 0 = 1, the oldest bit lands in output bit 0. With bit 0 = 0, it lands in bit n-1. Output bits n..36 are zero.
- R5: A take is not offered (`out_valid_o` low) and not accepted while fewer than n bits are stored. It completes once enough bits arrive.
- R6: An output operation whose take field is zero drops the number of oldest bits given in bits 7..2. A drop never raises `out_valid_o`.
- R7: Any count field above 37 acts as 37.
- R8: Capacity is 96 bits, at least two full words. An append is refused while the stored count plus n exceeds 96.
- R9: Bits appended by consecutive input operations are concatenated in arrival order, and can be read out by a single take.
- R10: When the take field is nonzero, the drop field is ignored. Exactly the take count is removed.
- R11: A take holds `out_valid_o` with stable data and leaves the queue unchanged until `out_ready_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_data_i | input | 37 | Data word to append from |
| in_valid_i | input | 1 | Data word valid |
| in_ready_o | output | 1 | Data word accepted |
| inop_i | input | 14 | Append operation: order bit 0, count bits 13..8 |
| inop_valid_i | input | 1 | Append operation valid |
| inop_ready_o | output | 1 | Append operation accepted |
| out_data_o | output | 37 | Right-aligned taken bits |
| out_valid_o | output | 1 | Output word valid |
| out_ready_i | input | 1 | Consumer ready for output word |
| outop_i | input | 14 | Output operation: order bit 0, drop bits 7..2, take bits 13..8 |
| outop_valid_i | input | 1 | Output operation valid |
| outop_ready_o | output | 1 | Output operation accepted |

## Verification
The assertions assume that valid signals and their operation words are stable and known whenever the clock samples them. They also assume that a drop, like any other operation, is presented only through the normal handshake. The bench drives every input at the falling edge and holds operation words until the matching ready is seen. It releases valid one step after the accepting rising edge, so no operation is half-presented. Long waiting operations are left pending only in the cases that deliberately probe stalls.

// File: rtl/bit_fifo_pkg.sv
package bit_fifo_pkg;
  localparam int WORD_W   = 37;
  localparam int OP_W     = 14;
  localparam int LEN_W    = 6;
  localparam int ORD_BIT  = 0;
  localparam int DROP_LO  = 2;
  localparam int TAKE_LO  = 8;

  function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] f);
    return (int'(f) > WORD_W) ? LEN_W'(WORD_W) : f;
  endfunction

  function automatic logic [WORD_W-1:0] low_mask(input logic [LEN_W-1:0] n);
    if (n == '0) return '0;
    return {WORD_W{1'b1}} >> (WORD_W - int'(n));
  endfunction

  // reverse the low n bits, result right-aligned
  function automatic logic [WORD_W-1:0] rev_low(input logic [WORD_W-1:0] w,
                                                input logic [LEN_W-1:0] n);
    logic [WORD_W-1:0] r;
    for (int i = 0; i < WORD_W; i++) r[i] = w[WORD_W-1-i];
    if (n == '0) return '0;
    return r >> (WORD_W - int'(n));
  endfunction
endpackage

// File: rtl/bit_fifo_in_side.sv
module bit_fifo_in_side
  import bit_fifo_pkg::*;
#(
  parameter int CAP_BITS = 96,
  localparam int CNT_W = $clog2(CAP_BITS + 1)
) (
  input  logic [WORD_W-1:0] data_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [WORD_W-1:0] field_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              room_o
);
  logic lsb_first;
  logic unused_op;

  assign unused_op = ^op_i[TAKE_LO-1:ORD_BIT+1];
  assign lsb_first = op_i[ORD_BIT];
  assign len_o     = clamp_len(op_i[TAKE_LO +: LEN_W]);
  assign field_o   = lsb_first ? (data_i & low_mask(len_o)) : rev_low(data_i, len_o);
  assign room_o    = (int'(cnt_i) + int'(len_o)) <= CAP_BITS;
endmodule

// File: rtl/bit_fifo_out_side.sv
module bit_fifo_out_side
  import bit_fifo_pkg::*;
#(
  parameter int CAP_BITS = 96,
  localparam int CNT_W = $clog2(CAP_BITS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OP_W-1:0]   op_i,
  input  logic [WORD_W-1:0] head_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              is_take_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              enough_o,
  output logic [WORD_W-1:0] data_o
);
  logic [LEN_W-1:0]  take_n, drop_n;
  logic [WORD_W-1:0] raw;
  logic              unused_op;

  assign unused_op = op_i[1];
  assign take_n    = clamp_len(op_i[TAKE_LO +: LEN_W]);
  assign drop_n    = clamp_len(op_i[DROP_LO +: LEN_W]);
  assign is_take_o = take_n != '0;
  // take wins over drop
  assign len_o     = is_take_o ? take_n : drop_n;
  assign enough_o  = int'(cnt_i) >= int'(len_o);
  assign raw       = head_i & low_mask(take_n);
  assign data_o    = op_i[ORD_BIT] ? raw : rev_low(raw, take_n);

  // R4
  upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_take_o |-> ((data_o >> take_n) == '0));
endmodule

// File: rtl/bit_fifo_store.sv
module bit_fifo_store
  import bit_fifo_pkg::*;
#(
  parameter int CAP_BITS = 96,
  localparam int CNT_W = $clog2(CAP_BITS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [LEN_W-1:0]  push_len_i,
  input  logic [WORD_W-1:0] push_field_i,
  input  logic              pop_i,
  input  logic [LEN_W-1:0]  pop_len_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [WORD_W-1:0] head_o
);
  logic [CAP_BITS-1:0] bits_q, bits_d, kept, ins;
  logic [CNT_W-1:0]    cnt_q, cnt_d, cnt_mid, pop_amt, push_amt;

  assign pop_amt  = pop_i  ? CNT_W'(pop_len_i)  : '0;
  assign push_amt = push_i ? CNT_W'(push_len_i) : '0;

  always_comb begin
    kept    = bits_q >> pop_amt;
    cnt_mid = cnt_q - pop_amt;
    ins     = push_i ? (CAP_BITS'(push_field_i) << cnt_mid) : '0;
    bits_d  = kept | ins;
    cnt_d   = cnt_mid + push_amt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bits_q <= '0;
      cnt_q  <= '0;
    end else begin
      bits_q <= bits_d;
      cnt_q  <= cnt_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign head_o = bits_q[WORD_W-1:0];

  // R8
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_q) <= CAP_BITS);
  // R11
  idle_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!push_i && !pop_i) |=> ($stable(cnt_q) && $stable(bits_q)));
endmodule

// File: rtl/bit_fifo.sv
module bit_fifo
  import bit_fifo_pkg::*;
#(
  parameter int CAP_BITS = 96,
  localparam int CNT_W = $clog2(CAP_BITS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] in_data_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [OP_W-1:0]   inop_i,
  input  logic              inop_valid_i,
  output logic              inop_ready_o,
  output logic [WORD_W-1:0] out_data_o,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  input  logic [OP_W-1:0]   outop_i,
  input  logic              outop_valid_i,
  output logic              outop_ready_o
);
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] head, field;
  logic [LEN_W-1:0]  in_len, out_len;
  logic              room, is_take, enough, push, pop;

  bit_fifo_in_side #(.CAP_BITS(CAP_BITS)) u_in (
    .data_i(in_data_i), .op_i(inop_i), .cnt_i(cnt),
    .field_o(field), .len_o(in_len), .room_o(room)
  );

  bit_fifo_out_side #(.CAP_BITS(CAP_BITS)) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(outop_i), .head_i(head), .cnt_i(cnt),
    .is_take_o(is_take), .len_o(out_len), .enough_o(enough), .data_o(out_data_o)
  );

  bit_fifo_store #(.CAP_BITS(CAP_BITS)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .push_i(push), .push_len_i(in_len), .push_field_i(field),
    .pop_i(pop), .pop_len_i(out_len),
    .cnt_o(cnt), .head_o(head)
  );

  assign in_ready_o    = inop_valid_i & room;
  assign inop_ready_o  = in_valid_i & room;
  assign push          = in_valid_i & inop_valid_i & room;
  assign out_valid_o   = outop_valid_i & is_take & enough;
  assign outop_ready_o = enough & (~is_take | out_ready_i);
  assign pop           = outop_valid_i & outop_ready_o;

  // R2
  in_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |-> (inop_valid_i && inop_ready_o));
  // R6
  drop_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (outop_valid_i && outop_i[TAKE_LO +: LEN_W] == '0) |-> !out_valid_o);
  // R11
  hold_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i && !push && $stable(outop_i)) |=>
      (!outop_valid_i || $stable(out_data_o)));
endmodule

// File: tb/sim_bit_fifo.sv
`timescale 1ns/1ps
module sim_bit_fifo;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 0, rst_ni = 0;
  logic [36:0] in_data_i = '0;
  logic        in_valid_i = 0, inop_valid_i = 0, out_ready_i = 0, outop_valid_i = 0;
  logic [13:0] inop_i = '0, outop_i = '0;
  logic [36:0] out_data_o;
  logic        in_ready_o, inop_ready_o, out_valid_o, outop_ready_o;

  int total = 0, fails = 0;

  bit_fifo u0 (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // R3 R4 R7 vectors: data, append op, output op, expected word
  localparam logic [36:0] V_DATA [6] = '{37'd1, 37'd1, 37'd5, 37'd6, 37'hFF, 37'h1F_FFFF_FFFF};
  localparam logic [13:0] V_IOP  [6] = '{14'h2501, 14'h2501, 14'h0300, 14'h0301, 14'h0401, 14'h3F01};
  localparam logic [13:0] V_OOP  [6] = '{14'h2501, 14'h2500, 14'h0300, 14'h0300, 14'h0401, 14'h3F01};
  localparam logic [36:0] V_EXP  [6] = '{37'd1, 37'h10_0000_0000, 37'd5, 37'd3, 37'hF, 37'h1F_FFFF_FFFF};

  task automatic chk(input string req, input logic [36:0] act, input logic [36:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [36:0] d, input logic [13:0] op);
    @(negedge clk_i);
    in_data_i = d; inop_i = op; in_valid_i = 1; inop_valid_i = 1;
    #1;
    while (!in_ready_o) begin @(negedge clk_i); #1; end
    @(posedge clk_i); #1;
    in_valid_i = 0; inop_valid_i = 0;
  endtask

  task automatic pull(input logic [13:0] op, output logic [36:0] d);
    @(negedge clk_i);
    outop_i = op; outop_valid_i = 1; out_ready_i = 1;
    #1;
    while (!outop_ready_o) begin @(negedge clk_i); #1; end
    d = out_data_o;
    @(posedge clk_i); #1;
    outop_valid_i = 0;
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    fails++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [36:0] d;
    // R1 reset state
    outop_i = 14'h0101; outop_valid_i = 1; out_ready_i = 1;
    #(CLK_PERIOD*2 + 2);
    chk("R1 out_valid in reset", 37'(out_valid_o), 37'd0);
    @(negedge clk_i); rst_ni = 1;
    @(negedge clk_i); #1;
    chk("R1 out_valid empty", 37'(out_valid_o), 37'd0);
    chk("R1 take not accepted", 37'(outop_ready_o), 37'd0);
    outop_valid_i = 0;

    for (int i = 0; i < 6; i++) begin
      push(V_DATA[i], V_IOP[i]);
      pull(V_OOP[i], d);
      chk($sformatf("R3/R4/R7 vector %0d", i), d, V_EXP[i]);
    end

    // R2 data alone is not consumed
    @(negedge clk_i); in_valid_i = 1; inop_i = 14'h0101; #1;
    chk("R2 in_ready without op", 37'(in_ready_o), 37'd0);
    in_valid_i = 0;

    // R9 packing across writes
    push(37'hA, 14'h0401);
    push(37'h3, 14'h0201);
    pull(14'h0601, d);
    chk("R9 packed take", d, 37'h3A);

    // R6 drop oldest, then take
    push(37'hF0, 14'h0801);
    @(negedge clk_i); outop_i = 14'h0010; outop_valid_i = 1; #1;
    chk("R6 drop gives no output", 37'(out_valid_o), 37'd0);
    @(posedge clk_i); #1; outop_valid_i = 0;
    pull(14'h0401, d);
    chk("R6 bits after drop", d, 37'hF);

    // R10 drop field ignored on take
    push(37'h3, 14'h0201);
    pull(14'h0215, d);
    chk("R10 take value", d, 37'h3);
    @(negedge clk_i); outop_i = 14'h0101; outop_valid_i = 1; #1;
    chk("R10 queue empty after take", 37'(outop_ready_o), 37'd0);

    // R5 take waits for data
    chk("R5 stall offer", 37'(out_valid_o), 37'd0);
    push(37'h1, 14'h0101);
    @(negedge clk_i); #1;
    chk("R5 offered after arrival", 37'(out_valid_o), 37'd1);
    chk("R5 data after arrival", out_data_o, 37'h1);
    @(posedge clk_i); #1; outop_valid_i = 0;

    // R11 backpressure
    push(37'h2, 14'h0201);
    @(negedge clk_i); outop_i = 14'h0201; outop_valid_i = 1; out_ready_i = 0; #1;
    chk("R11 valid under stall", 37'(out_valid_o), 37'd1);
    chk("R11 op held", 37'(outop_ready_o), 37'd0);
    @(negedge clk_i); #1;
    chk("R11 data held", out_data_o, 37'h2);
    out_ready_i = 1;
    @(posedge clk_i); #1; outop_valid_i = 0;

    // R8 capacity
    push('0, 14'h2501);
    push('0, 14'h2501);
    push('0, 14'h1601);
    @(negedge clk_i); in_valid_i = 1; inop_valid_i = 1; inop_i = 14'h0101; #1;
    chk("R8 full refuses append", 37'(in_ready_o), 37'd0);
    in_valid_i = 0; inop_valid_i = 0;
    pull(14'h0094, d);
    pull(14'h0094, d);
    pull(14'h0058, d);
    @(negedge clk_i); outop_i = 14'h0101; outop_valid_i = 1; #1;
    chk("R8 drained empty", 37'(outop_ready_o), 37'd0);
    outop_valid_i = 0;

    summary();
    $finish;
  end
endmodule